// File: doc/BRIEF.md
# Block Averager with Shift-Add Scaling

This block gathers a fixed number of signed converter samples into a wide signed accumulator and, once the block is complete, produces an approximate mean without a hardware divider. Each sample is taken only when its valid strobe is high. A parameter picks the length and the scaling method. A power-of-two length 2^n divides by dropping the n low bits of the total, with optional round-half-up. A length of 1000 adds three arithmetic right shifts of the total (by 10, 16 and 17 bits). That computes total/1024 · (1 + 1/64 + 1/128), which is close to total/1000.

The result appears one clock after the edge that accepts the last sample of a block, together with a one-cycle valid pulse. The next accepted sample then starts a fresh total. A synchronous restart input lines the block boundary up with an external sampling trigger. It discards any partial block, and the sample offered in the restart cycle is also discarded.

Top module: `block_averager`

## Requirements
- R1: Each SAMPLE_W-bit input is treated as two's complement and sign-extended before accumulation, so negative samples reduce the total (eight samples of -8192 average to -8192 in power-of-two mode with n=3).
- R2: In power-of-two mode with rounding off, avg_out equals floor(total / 2^LOG2N), where total is the sum of the 2^LOG2N samples of the block.
- R3: In power-of-two mode with rounding on, avg_out equals floor((total + 2^(LOG2N-1)) / 2^LOG2N).
- R4: In 1000-sample mode, avg_out equals floor(total/2^10) + floor(total/2^16) + floor(total/2^17), computed without a divider or multiplier.
- R5: out_valid is high for exactly one cycle, the cycle after the clock edge that accepts the last sample of a block. avg_out keeps its value until the next such pulse.
- R6: The first accepted sample after a completed block starts a new total. No part of the previous block carries over.
- R7: Cycles with in_valid low change neither the sample count nor the total, whatever value is on in_sample.
- R8: restart_i high at a clock edge sets the sample count to zero and discards the partial total. A sample offered in that same cycle is not accepted, and no result is produced for the discarded block.
- R9: While rst_n is low, and until the first result after release, out_valid is 0 and avg_out is 0.
- R10: All divisions by shifting are arithmetic, so a negative total gives a negative average rounded toward minus infinity (1000 samples of -8192 give -8188).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| restart_i | input | 1 | Synchronous restart aligned to the external sampling trigger |
| in_valid | input | 1 | Sample strobe; in_sample is accepted when high |
| in_sample | input | SAMPLE_W | Signed converter sample |
| out_valid | output | 1 | One-cycle pulse marking a new average |
| avg_out | output | ACC_W | Signed scaled average, held between pulses |

## Verification
The embedded properties assume that restart_i and in_valid are clean synchronous levels. They also assume every block length is at least two samples, so two result pulses can never fall on adjacent cycles. The stimulus drives all inputs on the falling clock edge, holds restart_i for a single cycle, and uses only full-scale or in-range samples, so the 24-bit total never overflows for the tested lengths. The default ACC_W is sized for 1000 full-scale samples. The bench keeps its own count and running total per configuration and derives each expected average from the formulas above.

// File: rtl/blkavg_pkg.sv
package blkavg_pkg;

  // Scaling method chosen at elaboration time
  typedef enum logic {
    SCALE_POW2  = 1'b0,
    SCALE_K1000 = 1'b1
  } scale_mode_e;

  localparam int unsigned K1000_LEN = 1000;

endpackage

// File: rtl/blkavg_rst_sync.sv
module blkavg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/blkavg_counter.sv
module blkavg_counter #(
  parameter int unsigned BLOCK_LEN = 16,
  localparam int unsigned CNT_W    = $clog2(BLOCK_LEN)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic accept,
  output logic first,
  output logic last
);

  localparam logic [CNT_W-1:0] TERM = CNT_W'(BLOCK_LEN - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  assign first = (cnt_q == '0);
  assign last  = (cnt_q == TERM);

  always_comb begin
    cnt_d = cnt_q;
    if (restart) begin
      cnt_d = '0;
    end else if (accept) begin
      if (last) cnt_d = '0;
      else      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R8
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !accept) |=> $stable(cnt_q));

  // R6
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TERM);

endmodule

// File: rtl/blkavg_accum.sv
module blkavg_accum #(
  parameter int unsigned SAMPLE_W = 14,
  parameter int unsigned ACC_W    = 24
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       accept,
  input  logic                       first,
  input  logic signed [SAMPLE_W-1:0] sample,
  output logic signed [ACC_W-1:0]    total
);

  localparam int unsigned EXT_W = ACC_W - SAMPLE_W;

  logic signed [ACC_W-1:0] ext;
  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] acc_d;

  // Replicate the sample sign into the upper accumulator bits
  assign ext = {{EXT_W{sample[SAMPLE_W-1]}}, sample};

  // Total including the sample on the inputs; a new block reloads
  assign total = first ? ext : (acc_q + ext);

  always_comb begin
    acc_d = acc_q;
    if (accept) acc_d = total;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  // R7
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(acc_q));

  // R1
  sign_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && first) |=> (acc_q[ACC_W-1] == $past(sample[SAMPLE_W-1])));

endmodule

// File: rtl/blkavg_scale.sv
module blkavg_scale
  import blkavg_pkg::*;
#(
  parameter int unsigned ACC_W    = 24,
  parameter scale_mode_e MODE     = SCALE_POW2,
  parameter int unsigned LOG2N    = 4,
  parameter bit          ROUND_EN = 1'b1
) (
  input  logic signed [ACC_W-1:0] total,
  output logic signed [ACC_W-1:0] avg
);

  generate
    if (MODE == SCALE_K1000) begin : g_k1000
      // total/1024 * (1 + 1/64 + 1/128) with two adders
      logic signed [ACC_W-1:0] sh10;
      logic signed [ACC_W-1:0] sh16;
      logic signed [ACC_W-1:0] sh17;
      assign sh10 = total >>> 10;
      assign sh16 = total >>> 16;
      assign sh17 = total >>> 17;
      assign avg  = sh10 + sh16 + sh17;
    end else if (ROUND_EN) begin : g_round
      localparam logic [ACC_W:0] HALF = {{ACC_W{1'b0}}, 1'b1} << (LOG2N - 1);
      logic        [ACC_W:0] biased;
      logic signed [ACC_W:0] shifted;
      assign biased  = {total[ACC_W-1], total} + HALF;
      assign shifted = $signed(biased) >>> LOG2N;
      assign avg     = ACC_W'(shifted);
    end else begin : g_trunc
      assign avg = total >>> LOG2N;
    end
  endgenerate

endmodule

// File: rtl/block_averager.sv
module block_averager
  import blkavg_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 14,
  parameter int unsigned ACC_W    = 24,
  parameter scale_mode_e MODE     = SCALE_POW2,
  parameter int unsigned LOG2N    = 4,
  parameter bit          ROUND_EN = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                restart_i,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_sample,
  output logic                out_valid,
  output logic [ACC_W-1:0]    avg_out
);

  localparam int unsigned BLOCK_LEN =
    (MODE == SCALE_K1000) ? K1000_LEN : (32'd1 << LOG2N);

  logic                    rst_n_sync;
  logic                    accept;
  logic                    first;
  logic                    last;
  logic signed [ACC_W-1:0] total;
  logic signed [ACC_W-1:0] scaled;
  logic                    done;
  logic                    valid_q;
  logic                    valid_d;
  logic [ACC_W-1:0]        avg_q;
  logic [ACC_W-1:0]        avg_d;

  blkavg_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  // Restart wins over a coincident sample
  assign accept = in_valid && !restart_i;

  blkavg_counter #(
    .BLOCK_LEN (BLOCK_LEN)
  ) u_counter (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .restart (restart_i),
    .accept  (accept),
    .first   (first),
    .last    (last)
  );

  blkavg_accum #(
    .SAMPLE_W (SAMPLE_W),
    .ACC_W    (ACC_W)
  ) u_accum (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .accept (accept),
    .first  (first),
    .sample ($signed(in_sample)),
    .total  (total)
  );

  blkavg_scale #(
    .ACC_W    (ACC_W),
    .MODE     (MODE),
    .LOG2N    (LOG2N),
    .ROUND_EN (ROUND_EN)
  ) u_scale (
    .total (total),
    .avg   (scaled)
  );

  assign done = accept && last;

  always_comb begin
    valid_d = done;
    avg_d   = avg_q;
    if (done) avg_d = scaled;
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      valid_q <= 1'b0;
      avg_q   <= '0;
    end else begin
      valid_q <= valid_d;
      avg_q   <= avg_d;
    end
  end

  assign out_valid = valid_q;
  assign avg_out   = avg_q;

  // R5
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    out_valid |=> !out_valid);

  // R5
  avg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !out_valid |-> $stable(avg_out));

  // R8
  pulse_source_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    out_valid |-> ($past(in_valid) && !$past(restart_i)));

  // R8
  no_result_on_restart_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    restart_i |=> !out_valid);

endmodule

// File: tb/test_block_averager.sv
module test_block_averager;
  import blkavg_pkg::*;

  localparam time CLK_PERIOD = 10ns;
  localparam int  NTAB       = 20;

  localparam bit VEC_V [NTAB] = '{
    1, 1, 1, 0, 1, 1, 1, 1, 1,
    1, 1, 1, 1, 0, 1, 1, 1, 1, 0, 0
  };
  localparam int VEC_S [NTAB] = '{
    100, 200, -50, 8191, 300, 7, -1, 1000, 5,
    13, -8192, -8192, -3, -8191, -7, -9, -100, -4, 77, -77
  };

  logic        clk;
  logic        rst_n;
  logic        restart;
  logic        in_valid;
  logic [13:0] in_sample;
  logic        ov_a, ov_b, ov_c;
  logic [23:0] avg_a, avg_b, avg_c;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int  cnt8 = 0, sum8 = 0, cnt1k = 0, sum1k = 0;
  bit  pend8 = 0, pend1k = 0;
  int  exp_sum8 = 0, exp_sum1k = 0;
  int  last_a = 0, last_c = 0;
  string tag_a = "R2", tag_b = "R3", tag_c = "R4";

  block_averager #(.MODE(SCALE_POW2), .LOG2N(3), .ROUND_EN(1'b0)) i_block_averager (
    .clk(clk), .rst_n(rst_n), .restart_i(restart), .in_valid(in_valid),
    .in_sample(in_sample), .out_valid(ov_a), .avg_out(avg_a));

  block_averager #(.MODE(SCALE_POW2), .LOG2N(3), .ROUND_EN(1'b1)) i_block_averager_rnd (
    .clk(clk), .rst_n(rst_n), .restart_i(restart), .in_valid(in_valid),
    .in_sample(in_sample), .out_valid(ov_b), .avg_out(avg_b));

  block_averager #(.MODE(SCALE_K1000), .LOG2N(3), .ROUND_EN(1'b0)) i_block_averager_k (
    .clk(clk), .rst_n(rst_n), .restart_i(restart), .in_valid(in_valid),
    .in_sample(in_sample), .out_valid(ov_c), .avg_out(avg_c));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int sx(logic [23:0] v);
    return int'($signed(v));
  endfunction

  // One cycle: check outputs of the previous edge, then drive new inputs
  task automatic step(bit v, int s, bit r);
    int ea, eb, ec;
    @(negedge clk);
    chk(ov_a == pend8, "R5", int'(ov_a), int'(pend8));
    chk(ov_b == pend8, "R5", int'(ov_b), int'(pend8));
    chk(ov_c == pend1k, "R5", int'(ov_c), int'(pend1k));
    if (pend8) begin
      ea = exp_sum8 >>> 3;
      eb = (exp_sum8 + 4) >>> 3;
      chk(sx(avg_a) == ea, tag_a, sx(avg_a), ea);
      chk(sx(avg_b) == eb, tag_b, sx(avg_b), eb);
      last_a = ea;
    end else begin
      chk(sx(avg_a) == last_a, "R5", sx(avg_a), last_a);
    end
    if (pend1k) begin
      ec = (exp_sum1k >>> 10) + (exp_sum1k >>> 16) + (exp_sum1k >>> 17);
      chk(sx(avg_c) == ec, tag_c, sx(avg_c), ec);
      last_c = ec;
    end
    pend8  = 0;
    pend1k = 0;
    restart   = r;
    in_valid  = v;
    in_sample = 14'(s);
    if (r) begin
      cnt8 = 0; sum8 = 0; cnt1k = 0; sum1k = 0;
    end else if (v) begin
      sum8  = (cnt8 == 0) ? s : sum8 + s;
      sum1k = (cnt1k == 0) ? s : sum1k + s;
      cnt8++;
      cnt1k++;
      if (cnt8 == 8)     begin pend8 = 1;  exp_sum8 = sum8;   cnt8 = 0;  end
      if (cnt1k == 1000) begin pend1k = 1; exp_sum1k = sum1k; cnt1k = 0; end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; restart = 1'b0; in_valid = 1'b0; in_sample = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(!ov_a && !ov_b && !ov_c, "R9", int'(ov_a | ov_b | ov_c), 0);
    chk(avg_a == '0 && avg_c == '0, "R9", sx(avg_a), 0);
    rst_n = 1'b1;
    repeat (4) step(1'b0, 0, 1'b0);
    chk(avg_b == '0, "R9", sx(avg_b), 0);

    // Table walk: two blocks with idle gaps carrying garbage (R7) and reload (R6)
    for (int i = 0; i < NTAB; i++) begin
      tag_a = (i >= 9) ? "R6" : "R2";
      step(VEC_V[i], VEC_S[i], 1'b0);
    end
    tag_a = "R2";
    repeat (2) step(1'b0, 0, 1'b0);

    // R8: partial block, restart with a coincident sample, then a clean block
    for (int i = 0; i < 5; i++) step(1'b1, 1000, 1'b0);
    step(1'b1, 999, 1'b1);
    for (int i = 0; i < 8; i++) step(1'b1, 3, 1'b0);
    step(1'b0, 0, 1'b0);
    chk(sx(avg_a) == 3, "R8", sx(avg_a), 3);

    // R7: samples interleaved with invalid full-scale garbage
    for (int i = 0; i < 8; i++) begin
      step(1'b1, 2, 1'b0);
      step(1'b0, 8191, 1'b0);
    end
    chk(sx(avg_a) == 2, "R7", sx(avg_a), 2);

    // R1: full-scale negative samples
    for (int i = 0; i < 8; i++) step(1'b1, -8192, 1'b0);
    step(1'b0, 0, 1'b0);
    chk(sx(avg_a) == -8192, "R1", sx(avg_a), -8192);
    chk(sx(avg_b) == -8192, "R1", sx(avg_b), -8192);

    // R3: exact half on a negative total (-12/8 = -1.5)
    tag_a = "R10";
    for (int i = 0; i < 4; i++) step(1'b1, -3, 1'b0);
    for (int i = 0; i < 4; i++) step(1'b1, 0, 1'b0);
    step(1'b0, 0, 1'b0);
    chk(sx(avg_a) == -2, "R10", sx(avg_a), -2);
    chk(sx(avg_b) == -1, "R3", sx(avg_b), -1);
    tag_a = "R2";

    // R4: 1000-sample mode, positive full scale, aligned by restart
    step(1'b0, 0, 1'b1);
    for (int i = 0; i < 1000; i++) step(1'b1, 8191, 1'b0);
    step(1'b0, 0, 1'b0);
    chk(sx(avg_c) == 8185, "R4", sx(avg_c), 8185);

    // R10: 1000-sample mode, negative full scale
    tag_c = "R10";
    for (int i = 0; i < 1000; i++) step(1'b1, -8192, 1'b0);
    step(1'b0, 0, 1'b0);
    chk(sx(avg_c) == -8188, "R10", sx(avg_c), -8188);
    repeat (3) step(1'b0, 0, 1'b0);
    chk(sx(avg_c) == last_c, "R5", sx(avg_c), last_c);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule